// File: doc/BRIEF.md
# Armed Latch Strobe Generator

This block produces the clock for a latch domain behind an SPI-style control port. A register bank clocked by the strobe takes new data on its rising edge. That edge comes when the port is deselected, and only if the serial clock actually rose while this block's target was selected. A select pulse that carries no serial clock edge leaves the strobe high, so a stray or glitching select can never load the register bank.

The active-low chip select and the target address are brought into the system-clock domain through a short synchronizer chain. They are then decoded into a one-hot vector, and that vector is registered. Only the registered bit for the configured target feeds the strobe flop. That flop is preset asynchronously while the target is deselected, and it is clock-enabled on the serial clock while the target is selected, loading a constant zero. As a result, the asynchronous preset is driven from a flop and never from decode logic.

Usage rule: chip select and address must be stable for at least `SYNC_STAGES + 1` system-clock cycles before the first rising serial clock edge of a frame. Serial clock edges that come earlier may not arm the strobe.

Top module: `ltch_strobe_gen`

## Requirements
- R1: During reset and after reset is released with no activity, `le_clk` is high.
- R2: While the target is not selected, `le_clk` stays high, whatever `sck` does.
- R3: The first rising `sck` edge after the registered select of the target goes active drives `le_clk` low. It stays low until deselection.
- R4: After `cs_n` returns high at the end of an armed frame, `le_clk` rises within `SYNC_STAGES + 2` system-clock cycles. Each such frame gives exactly one rising edge.
- R5: A frame to the target with no `sck` edge produces no rising edge on `le_clk`.
- R6: A `cs_n` low pulse lasting one system-clock cycle, with no `sck` edge, produces no rising edge on `le_clk`.
- R7: A frame whose `tgt_addr` differs from the parameter `TARGET`, with any number of `sck` edges, produces no rising edge on `le_clk`.
- R8: The registered decode selects at most one target. Decode bit i is active when `cs_n` is low and `tgt_addr` equals i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for select synchronization and decode |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; its rising edge arms the strobe |
| cs_n | input | 1 | Active-low chip select |
| tgt_addr | input | ADDR_W | Target address qualifying the chip select |
| le_clk | output | 1 | Latch-domain clock; its rising edge is the latch event |

## Verification
A stuck or mis-decoded select bit shows up at `le_clk` in one of two ways. Either the strobe fails to fall within a few system cycles of the first serial edge, or it produces an extra rising edge or misses one within `SYNC_STAGES + 2` cycles of deselection. Counting rising edges per frame therefore exposes a wrong arm state by the end of the same frame. A wrong preset path shows as a low strobe while deselected. That is visible on the next idle sample after serial clock activity.

// File: rtl/ltch_pkg.sv
package ltch_pkg;

  function automatic int unsigned addr_bits(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ltch_sel_sync.sv
module ltch_sel_sync #(
  parameter int NUM_TGT     = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [NUM_TGT-1:0] onehot_q
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_pipe;
  logic [ADDR_W-1:0]      addr_pipe [SYNC_STAGES];
  logic [NUM_TGT-1:0]     dec;

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe[k]   <= 1'b1;
          addr_pipe[k] <= '0;
        end else begin
          cs_pipe[k]   <= cs_n;
          addr_pipe[k] <= tgt_addr;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe[k]   <= 1'b1;
          addr_pipe[k] <= '0;
        end else begin
          cs_pipe[k]   <= cs_pipe[k-1];
          addr_pipe[k] <= addr_pipe[k-1];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_dec
    assign dec[i] = !cs_pipe[LAST] && (addr_pipe[LAST] == ADDR_W'(i));
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) onehot_q <= '0;
    else        onehot_q <= dec;
  end

  // R8: registered decode never selects two targets
  p_decode_onehot_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $onehot0(onehot_q));

endmodule

// File: rtl/ltch_strobe_cell.sv
module ltch_strobe_cell (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic sck,
  input  logic sel_q,
  output logic le_clk
);

  logic pre;
  logic ce;

  // single registered bit inverted: no decode glitch reaches the preset
  assign pre = ~sel_q;
  assign ce  = sel_q;

  always_ff @(posedge sck or posedge pre) begin
    if (pre)     le_clk <= 1'b1;
    else if (ce) le_clk <= 1'b0;
  end

  // R2: deselected target keeps the strobe high
  p_idle_high_r2: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !sel_q |-> le_clk);

  // R3: a low strobe only exists under an active select
  p_fall_needs_sel_r3: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $fell(le_clk) |-> sel_q);

  // R4: every latch edge coincides with the registered select dropping
  p_rise_on_desel_r4: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(le_clk) |-> $fell(sel_q));

endmodule

// File: rtl/ltch_strobe_gen.sv
module ltch_strobe_gen import ltch_pkg::*; #(
  parameter int NUM_TGT     = 8,
  parameter int TARGET      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = addr_bits(NUM_TGT)
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              le_clk
);

  localparam logic [NUM_TGT-1:0] TGT_MASK = NUM_TGT'(1) << TARGET;

  logic [NUM_TGT-1:0] onehot_q;

  ltch_sel_sync #(
    .NUM_TGT    (NUM_TGT),
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sel_sync (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .tgt_addr(tgt_addr),
    .onehot_q(onehot_q)
  );

  ltch_strobe_cell i_strobe (
    .clk_sys(clk_sys),
    .rst_n  (rst_n),
    .sck    (sck),
    .sel_q  (onehot_q[TARGET]),
    .le_clk (le_clk)
  );

  // R7: another target selected leaves this strobe high
  p_other_quiet_r7: assert property (@(posedge clk_sys) disable iff (!rst_n)
    ((onehot_q & ~TGT_MASK) != '0) |-> le_clk);

  // R1: strobe is high while reset is held
  always @(posedge clk_sys) begin
    if (!rst_n) p_reset_high_r1: assert (le_clk === 1'b1);
  end

endmodule

// File: tb/test_ltch_strobe_gen.sv
module test_ltch_strobe_gen;

  localparam int NUM_TGT = 8;
  localparam int TARGET  = 3;
  localparam int STAGES  = 2;
  localparam int AW      = 3;

  logic clk_sys = 1'b0;
  logic rst_n   = 1'b0;
  logic sck     = 1'b0;
  logic cs_n    = 1'b1;
  logic [AW-1:0] tgt_addr = '0;
  logic le_clk;

  int n_run  = 0;
  int n_fail = 0;
  int lat_cnt = 0;
  bit done = 1'b0;

  always #4 clk_sys = ~clk_sys;

  ltch_strobe_gen #(
    .NUM_TGT(NUM_TGT), .TARGET(TARGET), .SYNC_STAGES(STAGES)
  ) i_ltch_strobe_gen (
    .clk_sys(clk_sys), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .tgt_addr(tgt_addr), .le_clk(le_clk)
  );

  always @(posedge le_clk) if (rst_n) lat_cnt++;

  function automatic int exp_latches(int addr, int nbits);
    return (addr == TARGET && nbits > 0) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_sys);
  endtask

  task automatic frame(int addr, int nbits);
    int base;
    base = lat_cnt;
    @(negedge clk_sys);
    cs_n = 1'b0;
    tgt_addr = AW'(addr);
    wait_n(STAGES + 3);
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b1;
      wait_n(5);
      if (b == 0 && exp_latches(addr, nbits) == 1)
        check(le_clk == 1'b0, "R3 strobe low after first sck", int'(le_clk), 0);
      if (b == 0 && exp_latches(addr, nbits) == 0)
        check(le_clk == 1'b1, "R7 strobe high for other target", int'(le_clk), 1);
      sck = 1'b0;
      wait_n(5);
    end
    wait_n(2);
    cs_n = 1'b1;
    wait_n(STAGES + 2);
    check(le_clk == 1'b1, "R4 strobe high after deselect", int'(le_clk), 1);
    wait_n(4);
    if (addr == TARGET && nbits == 0)
      check(lat_cnt - base == 0, "R5 no latch without sck", lat_cnt - base, 0);
    else if (addr != TARGET)
      check(lat_cnt - base == 0, "R7 no latch for other target", lat_cnt - base, 0);
    else
      check(lat_cnt - base == 1, "R4 one latch per frame", lat_cnt - base, 1);
  endtask

  task automatic glitch();
    int base;
    base = lat_cnt;
    @(negedge clk_sys);
    tgt_addr = AW'(TARGET);
    cs_n = 1'b0;
    @(negedge clk_sys);
    cs_n = 1'b1;
    wait_n(STAGES + 6);
    check(lat_cnt - base == 0, "R6 no latch on select glitch", lat_cnt - base, 0);
    check(le_clk == 1'b1, "R6 strobe high after glitch", int'(le_clk), 1);
  endtask

  task automatic idle_sck(int n);
    int base;
    base = lat_cnt;
    cs_n = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_sys) sck = 1'b1;
      wait_n(2);
      check(le_clk == 1'b1, "R2 strobe high while deselected", int'(le_clk), 1);
      sck = 1'b0;
      wait_n(2);
    end
    check(lat_cnt - base == 0, "R2 no latch while deselected", lat_cnt - base, 0);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_n(3);
    check(le_clk == 1'b1, "R1 strobe high in reset", int'(le_clk), 1);
    rst_n = 1'b1;
    wait_n(5);
    check(le_clk == 1'b1, "R1 strobe high after reset", int'(le_clk), 1);

    idle_sck(4);
    frame(TARGET, 1);
    frame(TARGET, 8);
    frame(TARGET, 0);
    glitch();
    frame((TARGET + 1) % NUM_TGT, 8);
    frame(0, 3);
    frame(NUM_TGT - 1, 16);

    // R8: address changes between frames select only the addressed one
    for (int it = 0; it < 40; it++) begin
      int a;
      int nb;
      a  = ($urandom % 2 == 0) ? TARGET : int'($urandom % NUM_TGT);
      nb = int'($urandom % 17);
      case ($urandom % 6)
        0:       glitch();
        1:       idle_sck(1 + int'($urandom % 3));
        default: frame(a, nb);
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule